// File: doc/BRIEF.md
# Shadow-Buffered Receive Slot

This block is the final receive slot of a CAN controller, with a single shadow register in front of it. Frame reception, filtering and bus timing happen elsewhere. An accepted frame arrives as a one-cycle store request that carries an identifier and a payload. If the slot has been read and the shadow is empty, the frame goes straight into the slot. If the slot still holds unread data, the frame waits in the shadow.

Software reads the slot. It then clears the data-updated flag and, if needed, the external-request flag. Once both flags are clear, the slot reloads itself from the shadow and raises data-updated again. The overwrite flag tracks the shadow only: it reports that a waiting frame was lost because a newer frame replaced it.

Top module: `rx_shadow_slot`

## Requirements
- R1: After reset, slot identifier and payload are 0, and the data-updated, external-request and overwrite flags are 0.
- R2: A store while data-updated is 0 after this cycle's clear and the shadow is empty writes the frame into the slot. The slot contents and data-updated = 1 are visible one cycle later.
- R3: A store while data-updated stays 1 leaves the slot contents unchanged and places the frame in the shadow.
- R4: A store while the shadow is full, in a cycle with no shadow-to-slot copy, replaces the shadow frame and sets the overwrite flag one cycle later.
- R5: When the shadow is full and both data-updated and external-request are 0 after this cycle's clears and sets, the shadow frame is copied into the slot. Data-updated is 1 in the next cycle.
- R6: A shadow-to-slot copy clears the overwrite flag and marks the shadow empty.
- R7: A remote-request pulse sets the external-request flag one cycle later, and a software clear resets it. If both arrive in the same cycle, the set wins.
- R8: While the external-request flag stays 1, no shadow-to-slot copy takes place, even with data-updated at 0.
- R9: A store in the same cycle as a shadow-to-slot copy goes into the freshly emptied shadow without setting the overwrite flag. It reaches the slot at the next release.
- R10: A software clear of data-updated drops the flag to 0 one cycle later, unless a slot load happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| store_vld | input | 1 | One-cycle store request for an accepted frame |
| store_id | input | ID_W | Identifier of the frame being stored |
| store_data | input | DATA_W | Payload of the frame being stored |
| clr_upd | input | 1 | Software clear of the data-updated flag |
| clr_ext | input | 1 | Software clear of the external-request flag |
| rmt_req | input | 1 | Remote request seen for this slot; sets external-request |
| slot_id | output | ID_W | Identifier held in the slot |
| slot_data | output | DATA_W | Payload held in the slot |
| slot_upd | output | 1 | Data-updated flag |
| slot_ext | output | 1 | External-request flag |
| shd_ovw | output | 1 | Overwrite flag for the shadow |

## Verification
Every result is registered once. A store, a clear, a remote request or a release shows on the outputs exactly one clock after the edge that samples the stimulus. No result needs a second cycle. The bench drives each stimulus after a falling edge and waits for the next rising edge. It samples all five outputs a quarter period later, so each vector's expected row describes the state one edge after its inputs. Frames that wait in the shadow are observed only when a later release moves them into the slot.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  // Where an incoming frame is steered in a given cycle.
  typedef enum logic [1:0] {
    RT_NONE   = 2'd0,
    RT_SLOT   = 2'd1,
    RT_SHADOW = 2'd2
  } rxs_route_e;
endpackage

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       store_vld,
  input  logic       clr_upd,
  input  logic       clr_ext,
  input  logic       rmt_req,
  input  logic       upd_q,
  input  logic       shd_full,
  output logic       ext_q,
  output logic       copy,
  output rxs_route_e route
);
  logic upd_n;
  logic ext_n;

  // Flag values after this cycle's software action.
  always_comb begin
    upd_n = upd_q & ~clr_upd;
    ext_n = (ext_q & ~clr_ext) | rmt_req;
    copy  = shd_full & ~upd_n & ~ext_n;
    route = RT_NONE;
    if (store_vld) begin
      if (!copy && !shd_full && !upd_n) route = RT_SLOT;
      else                              route = RT_SHADOW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_n;
  end

  assert_ext_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_req |=> ext_q);
  assert_no_copy_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && !clr_ext) |-> !copy);
endmodule

// File: rtl/rxs_shadow.sv
module rxs_shadow #(
  parameter int ID_W   = 11,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_q,
  output logic              ovw_q,
  output logic [ID_W-1:0]   id_q,
  output logic [DATA_W-1:0] data_q
);
  logic full_d;
  logic ovw_d;

  always_comb begin
    full_d = wr | (full_q & ~rd);
    // A copy-out frees the shadow, so a same-cycle write is never a loss.
    ovw_d  = rd ? 1'b0 : (ovw_q | (wr & full_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovw_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      ovw_q  <= ovw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      data_q <= '0;
    end else if (wr) begin
      id_q   <= wr_id;
      data_q <= wr_data;
    end
  end

  assert_ovw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full_q && !rd) |=> ovw_q);
  assert_ovw_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !ovw_q);
  assert_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |=> (full_q && !ovw_q));
  assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !full_q);
endmodule

// File: rtl/rxs_slot.sv
module rxs_slot
  import rxs_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxs_route_e        route,
  input  logic              copy,
  input  logic              clr_upd,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ID_W-1:0]   shd_id,
  input  logic [DATA_W-1:0] shd_data,
  output logic              upd_q,
  output logic [ID_W-1:0]   id_q,
  output logic [DATA_W-1:0] data_q
);
  logic              load;
  logic              upd_d;
  logic [ID_W-1:0]   id_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    load   = copy | (route == RT_SLOT);
    id_d   = copy ? shd_id   : in_id;
    data_d = copy ? shd_data : in_data;
    upd_d  = load | (upd_q & ~clr_upd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      data_q <= '0;
    end else if (load) begin
      id_q   <= id_d;
      data_q <= data_d;
    end
  end

  assert_load_upd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> upd_q);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(id_q) && $stable(data_q)));
  assert_clr_upd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && clr_upd) |=> !upd_q);
endmodule

// File: rtl/rx_shadow_slot.sv
module rx_shadow_slot
  import rxs_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_vld,
  input  logic [ID_W-1:0]   store_id,
  input  logic [DATA_W-1:0] store_data,
  input  logic              clr_upd,
  input  logic              clr_ext,
  input  logic              rmt_req,
  output logic [ID_W-1:0]   slot_id,
  output logic [DATA_W-1:0] slot_data,
  output logic              slot_upd,
  output logic              slot_ext,
  output logic              shd_ovw
);
  rxs_route_e        route;
  logic              copy;
  logic              shd_full;
  logic [ID_W-1:0]   shd_id;
  logic [DATA_W-1:0] shd_data;

  rxs_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .store_vld(store_vld),
    .clr_upd  (clr_upd),
    .clr_ext  (clr_ext),
    .rmt_req  (rmt_req),
    .upd_q    (slot_upd),
    .shd_full (shd_full),
    .ext_q    (slot_ext),
    .copy     (copy),
    .route    (route)
  );

  rxs_shadow #(.ID_W(ID_W), .DATA_W(DATA_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (route == RT_SHADOW),
    .rd     (copy),
    .wr_id  (store_id),
    .wr_data(store_data),
    .full_q (shd_full),
    .ovw_q  (shd_ovw),
    .id_q   (shd_id),
    .data_q (shd_data)
  );

  rxs_slot #(.ID_W(ID_W), .DATA_W(DATA_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .route   (route),
    .copy    (copy),
    .clr_upd (clr_upd),
    .in_id   (store_id),
    .in_data (store_data),
    .shd_id  (shd_id),
    .shd_data(shd_data),
    .upd_q   (slot_upd),
    .id_q    (slot_id),
    .data_q  (slot_data)
  );

  assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_vld && !slot_upd && !slot_ext && !shd_full) |=>
      (slot_upd && slot_id == $past(store_id)));
endmodule

// File: tb/rx_shadow_slot_tb.sv
module rx_shadow_slot_tb;
  localparam int ID_W   = 11;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              store_vld;
  logic [ID_W-1:0]   store_id;
  logic [DATA_W-1:0] store_data;
  logic              clr_upd, clr_ext, rmt_req;
  logic [ID_W-1:0]   slot_id;
  logic [DATA_W-1:0] slot_data;
  logic              slot_upd, slot_ext, shd_ovw;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  rx_shadow_slot #(.ID_W(ID_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .store_vld(store_vld), .store_id(store_id),
    .store_data(store_data), .clr_upd(clr_upd), .clr_ext(clr_ext),
    .rmt_req(rmt_req), .slot_id(slot_id), .slot_data(slot_data),
    .slot_upd(slot_upd), .slot_ext(slot_ext), .shd_ovw(shd_ovw)
  );

  typedef struct packed {
    logic        st;
    logic [10:0] id;
    logic [15:0] dat;
    logic        cu;
    logic        ce;
    logic        rr;
    logic [10:0] e_id;
    logic [15:0] e_dat;
    logic        e_upd;
    logic        e_ext;
    logic        e_ovw;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  // st id dat cu ce rr | e_id e_dat upd ext ovw | requirement
  localparam vec_t VEC [NV] = '{
    '{1'b1, 11'h0A1, 16'h1111, 1'b0, 1'b0, 1'b0, 11'h0A1, 16'h1111, 1'b1, 1'b0, 1'b0, 4'd2},
    '{1'b1, 11'h0B2, 16'h2222, 1'b0, 1'b0, 1'b0, 11'h0A1, 16'h1111, 1'b1, 1'b0, 1'b0, 4'd3},
    '{1'b1, 11'h0C3, 16'h3333, 1'b0, 1'b0, 1'b0, 11'h0A1, 16'h1111, 1'b1, 1'b0, 1'b1, 4'd4},
    '{1'b0, 11'h000, 16'h0000, 1'b0, 1'b0, 1'b1, 11'h0A1, 16'h1111, 1'b1, 1'b1, 1'b1, 4'd7},
    '{1'b0, 11'h000, 16'h0000, 1'b1, 1'b0, 1'b0, 11'h0A1, 16'h1111, 1'b0, 1'b1, 1'b1, 4'd8},
    '{1'b0, 11'h000, 16'h0000, 1'b0, 1'b1, 1'b0, 11'h0C3, 16'h3333, 1'b1, 1'b0, 1'b0, 4'd5},
    '{1'b1, 11'h0D4, 16'h4444, 1'b0, 1'b0, 1'b0, 11'h0C3, 16'h3333, 1'b1, 1'b0, 1'b0, 4'd3},
    '{1'b1, 11'h0E5, 16'h5555, 1'b1, 1'b0, 1'b0, 11'h0D4, 16'h4444, 1'b1, 1'b0, 1'b0, 4'd9},
    '{1'b0, 11'h000, 16'h0000, 1'b1, 1'b0, 1'b0, 11'h0E5, 16'h5555, 1'b1, 1'b0, 1'b0, 4'd9},
    '{1'b0, 11'h000, 16'h0000, 1'b1, 1'b0, 1'b0, 11'h0E5, 16'h5555, 1'b0, 1'b0, 1'b0, 4'd10},
    '{1'b1, 11'h0F6, 16'h6666, 1'b0, 1'b0, 1'b0, 11'h0F6, 16'h6666, 1'b1, 1'b0, 1'b0, 4'd2},
    '{1'b0, 11'h000, 16'h0000, 1'b0, 1'b1, 1'b1, 11'h0F6, 16'h6666, 1'b1, 1'b1, 1'b0, 4'd7},
    '{1'b0, 11'h000, 16'h0000, 1'b0, 1'b1, 1'b0, 11'h0F6, 16'h6666, 1'b1, 1'b0, 1'b0, 4'd7}
  };

  task automatic check_out(input string tag, input logic [10:0] eid,
                           input logic [15:0] edat, input logic eu,
                           input logic ee, input logic eo);
    logic [DATA_W-1:0] ed;
    ed = {{(DATA_W-16){1'b0}}, edat};
    checks++;
    if (slot_id !== eid || slot_data !== ed || slot_upd !== eu ||
        slot_ext !== ee || shd_ovw !== eo) begin
      failures++;
      $display("FAIL %s: got id=%h data=%h upd=%b ext=%b ovw=%b exp id=%h data=%h upd=%b ext=%b ovw=%b",
               tag, slot_id, slot_data, slot_upd, slot_ext, shd_ovw,
               eid, ed, eu, ee, eo);
    end
  endtask

  task automatic step(input logic st, input logic [10:0] id,
                      input logic [15:0] dat, input logic cu,
                      input logic ce, input logic rr);
    @(negedge clk);
    store_vld  = st;
    store_id   = id;
    store_data = {{(DATA_W-16){1'b0}}, dat};
    clr_upd    = cu;
    clr_ext    = ce;
    rmt_req    = rr;
    @(posedge clk);
    #5;
    store_vld = 1'b0; clr_upd = 1'b0; clr_ext = 1'b0; rmt_req = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    store_vld = 1'b0; store_id = '0; store_data = '0;
    clr_upd = 1'b0; clr_ext = 1'b0; rmt_req = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check_out("R1 reset", 11'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].st, VEC[i].id, VEC[i].dat, VEC[i].cu, VEC[i].ce, VEC[i].rr);
      check_out($sformatf("R%0d vector %0d", VEC[i].req, i),
                VEC[i].e_id, VEC[i].e_dat, VEC[i].e_upd, VEC[i].e_ext, VEC[i].e_ovw);
    end

    // R8: ext held, updated cleared, shadow full: slot must not change.
    step(1'b1, 11'h111, 16'h7777, 1'b0, 1'b0, 1'b1);
    check_out("R8 ext held store to shadow", 11'h0F6, 16'h6666, 1'b1, 1'b1, 1'b0);
    step(1'b0, 11'h0, 16'h0, 1'b1, 1'b0, 1'b0);
    check_out("R8 no copy while ext", 11'h0F6, 16'h6666, 1'b0, 1'b1, 1'b0);
    // R4: second frame while shadow full, no copy.
    step(1'b1, 11'h222, 16'h8888, 1'b0, 1'b0, 1'b0);
    check_out("R4 shadow overwrite", 11'h0F6, 16'h6666, 1'b0, 1'b1, 1'b1);
    // R5/R6: release brings the latest shadow frame and clears overwrite.
    step(1'b0, 11'h0, 16'h0, 1'b0, 1'b1, 1'b0);
    check_out("R5 R6 release", 11'h222, 16'h8888, 1'b1, 1'b0, 1'b0);

    // R1: reset in the middle of activity.
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    check_out("R1 async reset", 11'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 11'h333, 16'h9999, 1'b0, 1'b0, 1'b0);
    check_out("R2 after reset", 11'h333, 16'h9999, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule